// File: doc/BRIEF.md
# Scatter-gather descriptor table builder

This block turns a stream of scatter segments into a table of 8-byte DMA descriptors held in a local table memory. Each segment is presented as a 32-bit bus address, a 17-bit byte length and a direction flag. A later engine walks the finished table. The table can be read back one entry per index through a combinational read port.

A segment that starts on a 4-byte boundary becomes a single transfer descriptor. A segment that starts off a boundary is split in two:
- a short head descriptor covers the bytes up to the next boundary and points at a 4-byte slot in a bounce area;
- a body descriptor covers the aligned remainder.

Each head raises a one-cycle bounce notice, so a separate copier can move those bytes. The copier learns the slot, the byte count and the direction. After a finish request the builder closes the table with a terminating entry and pulses done. The descriptor count stays on an output.

A start pulse opens a new table. Two faults stop building until the next start: a segment longer than one descriptor can carry, and a segment beyond the per-table limit.

Top module: `sg_table_builder`

## Requirements
- R1: Each table entry is a 64-bit word. Bits [7:0] hold the attribute, bits [15:8] are zero, bits [31:16] hold the 16-bit length, and bits [63:32] hold the address. `rd_data_o` shows the entry at `rd_idx_i` in the same cycle.
- R2: A segment with address bits [1:0] equal to zero and a length from 1 to 65536 writes one entry at the next index. That entry has attribute 0x21 and the segment's own address and length. A length of 65536 is stored as 0.
- R3: A segment with non-zero address bits [1:0] first writes a head entry. The head length is h = min((4 - addr[1:0]) mod 4, length), the attribute is 0x21 and the address is BOUNCE_BASE + 4 * slot. In the next cycle it writes a body entry at the following index, with address addr + h and length length - h. The body entry is omitted when length - h is zero. `seg_ready_o` is low for the one cycle after such a segment is accepted.
- R4: The bounce slot is 0 after a start and advances by one for every head entry. In the cycle after the accepting edge, `bnc_valid_o` is high for one cycle with the slot used, the head byte count and the segment's direction flag.
- R5: `finish_i`, sampled while segments are accepted and `seg_valid_i` is low, writes a terminating entry at the next index. That entry has attribute 0x03 and zero length and address. In the next cycle `done_o` is high for exactly one cycle and `desc_count_o` equals the number of entries written, including the terminating one.
- R6: A segment longer than 65536 bytes sets `err_too_big_o` and writes nothing. Later segments are ignored until the next start. A finish after that pulses `done_o` with the count of entries already written and writes no terminating entry.
- R7: At most MAX_SEG (128) segments are accepted per table. The next segment sets `err_overflow_o` and writes nothing. From then on the block behaves as in R6.
- R8: A zero-length segment writes no entry and raises no bounce notice.
- R9: After reset and before the first start, `seg_ready_o`, `done_o` and both error outputs are low. A start clears the entry count, the bounce slot, the segment count and both errors, and raises `seg_ready_o` in the next cycle.
- R10: The write index never goes past the table depth of 2 * MAX_SEG + 1 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that opens a new table |
| seg_valid_i | input | 1 | A segment is presented |
| seg_ready_o | output | 1 | The block takes the presented segment on this edge |
| seg_addr_i | input | 32 | Segment bus address |
| seg_len_i | input | 17 | Segment length in bytes |
| seg_to_card_i | input | 1 | Direction flag, forwarded with bounce notices |
| finish_i | input | 1 | Close the table |
| done_o | output | 1 | One-cycle pulse after the table is closed |
| desc_count_o | output | 9 | Entries written so far |
| err_too_big_o | output | 1 | Sticky: a segment exceeded 65536 bytes |
| err_overflow_o | output | 1 | Sticky: too many segments |
| bnc_valid_o | output | 1 | Bounce notice valid |
| bnc_slot_o | output | 7 | Bounce slot used by the head |
| bnc_bytes_o | output | 2 | Head byte count |
| bnc_to_card_o | output | 1 | Direction of the split segment |
| rd_idx_i | input | 9 | Table read index |
| rd_data_o | output | 64 | Table entry at rd_idx_i |

## Verification
The assertions assume that `start_i` and `finish_i` are pulses and that `finish_i` is never raised in the same cycle as `seg_valid_i`. They also assume that `seg_valid_i` with its address, length and direction holds steady until an edge on which `seg_ready_o` is high. The stimulus drives every input on the falling edge. It holds a segment until the accepting edge and drops valid afterwards. It raises finish only when no segment is pending, and issues each start as a one-cycle pulse. Within those limits it covers aligned, unaligned, tiny, empty, maximum and over-length segments, and a full 128-segment table.

// File: rtl/sgt_pkg.sv
package sgt_pkg;

  localparam logic [7:0] ATTR_XFER = 8'h21;
  localparam logic [7:0] ATTR_STOP = 8'h03;

  typedef enum logic [1:0] {ST_IDLE, ST_TAKE, ST_BODY} build_state_e;

  // Packed so that attr sits in bits [7:0] and addr in bits [63:32].
  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic [7:0]  rsvd;
    logic [7:0]  attr;
  } desc_t;

  // Bytes needed to reach the next 4-byte boundary, clipped to the length.
  function automatic logic [1:0] head_bytes(input logic [1:0] lo, input logic [16:0] len);
    logic [1:0] gap;
    gap = 2'(2'd0 - lo);
    if (17'(gap) > len) return len[1:0];
    return gap;
  endfunction

  function automatic desc_t make_desc(input logic [7:0] attr, input logic [15:0] len,
                                      input logic [31:0] addr);
    desc_t d;
    d.attr = attr;
    d.rsvd = 8'h00;
    d.len  = len;
    d.addr = addr;
    return d;
  endfunction

endpackage

// File: rtl/sgt_split.sv
module sgt_split #(
  parameter int LEN_W   = 17,
  parameter int MAX_LEN = 65536
) (
  input  logic [31:0]      addr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [1:0]       head_o,
  output logic             has_head_o,
  output logic [31:0]      body_addr_o,
  output logic [LEN_W-1:0] body_len_o,
  output logic             has_body_o,
  output logic             too_big_o
);
  import sgt_pkg::*;

  always_comb begin
    head_o      = head_bytes(addr_i[1:0], 17'(len_i));
    has_head_o  = (head_o != 2'd0);
    body_addr_o = addr_i + 32'(head_o);
    body_len_o  = len_i - LEN_W'(head_o);
    has_body_o  = (body_len_o != '0);
    too_big_o   = (len_i > LEN_W'(MAX_LEN));
  end

endmodule

// File: rtl/sgt_table_ram.sv
module sgt_table_ram #(
  parameter int DEPTH = 257,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [63:0]      wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [63:0]      rdata_o
);
  logic [63:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i && (waddr_i < IDX_W'(DEPTH))) mem[waddr_i] <= wdata_i;
  end

  always_comb begin
    if (raddr_i < IDX_W'(DEPTH)) rdata_o = mem[raddr_i];
    else                         rdata_o = '0;
  end

endmodule

// File: rtl/sg_table_builder.sv
module sg_table_builder #(
  parameter int          MAX_SEG     = 128,
  parameter int          LEN_W       = 17,
  parameter int          MAX_LEN     = 65536,
  parameter logic [31:0] BOUNCE_BASE = 32'h0000_1000,
  localparam int DEPTH  = 2 * MAX_SEG + 1,
  localparam int IDX_W  = $clog2(DEPTH + 1),
  localparam int SLOT_W = $clog2(MAX_SEG),
  localparam int SEGC_W = $clog2(MAX_SEG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              seg_valid_i,
  output logic              seg_ready_o,
  input  logic [31:0]       seg_addr_i,
  input  logic [LEN_W-1:0]  seg_len_i,
  input  logic              seg_to_card_i,
  input  logic              finish_i,
  output logic              done_o,
  output logic [IDX_W-1:0]  desc_count_o,
  output logic              err_too_big_o,
  output logic              err_overflow_o,
  output logic              bnc_valid_o,
  output logic [SLOT_W-1:0] bnc_slot_o,
  output logic [1:0]        bnc_bytes_o,
  output logic              bnc_to_card_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [63:0]       rd_data_o
);
  import sgt_pkg::*;

  build_state_e      state_q;
  logic [IDX_W-1:0]  wr_ptr_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SEGC_W-1:0] seg_cnt_q;
  logic [31:0]       pend_addr_q;
  logic [LEN_W-1:0]  pend_len_q;

  // Splitter outputs
  logic [1:0]       sp_head;
  logic             sp_has_head, sp_has_body, sp_big;
  logic [31:0]      sp_body_addr;
  logic [LEN_W-1:0] sp_body_len;

  sgt_split #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_split (
    .addr_i      (seg_addr_i),
    .len_i       (seg_len_i),
    .head_o      (sp_head),
    .has_head_o  (sp_has_head),
    .body_addr_o (sp_body_addr),
    .body_len_o  (sp_body_len),
    .has_body_o  (sp_has_body),
    .too_big_o   (sp_big)
  );

  // Named events, also used by the assertions
  logic halted, take, live_take, seg_full, ovf_evt, big_evt, good_take;
  logic head_evt, direct_evt, body_evt, end_evt, fin_evt, wr_en;
  logic [31:0] slot_addr;
  desc_t       wr_desc;

  assign seg_ready_o = (state_q == ST_TAKE);
  assign halted      = err_too_big_o | err_overflow_o;
  assign take        = seg_valid_i & seg_ready_o;
  assign live_take   = take & ~halted;
  assign seg_full    = (seg_cnt_q == SEGC_W'(MAX_SEG));
  assign ovf_evt     = live_take & seg_full;
  assign big_evt     = live_take & ~seg_full & sp_big;
  assign good_take   = live_take & ~seg_full & ~sp_big;
  assign head_evt    = good_take & sp_has_head;
  assign direct_evt  = good_take & ~sp_has_head & sp_has_body;
  assign body_evt    = (state_q == ST_BODY) & (pend_len_q != '0);
  assign fin_evt     = seg_ready_o & finish_i & ~seg_valid_i;
  assign end_evt     = fin_evt & ~halted;
  assign wr_en       = ~start_i & (head_evt | direct_evt | body_evt | end_evt);
  assign slot_addr   = BOUNCE_BASE + (32'(slot_q) << 2);

  always_comb begin
    wr_desc = make_desc(ATTR_STOP, 16'h0000, 32'h0);
    if (head_evt)        wr_desc = make_desc(ATTR_XFER, 16'(sp_head), slot_addr);
    else if (direct_evt) wr_desc = make_desc(ATTR_XFER, seg_len_i[15:0], seg_addr_i);
    else if (body_evt)   wr_desc = make_desc(ATTR_XFER, pend_len_q[15:0], pend_addr_q);
  end

  sgt_table_ram #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk     (clk),
    .we_i    (wr_en),
    .waddr_i (wr_ptr_q),
    .wdata_i (wr_desc),
    .raddr_i (rd_idx_i),
    .rdata_o (rd_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      wr_ptr_q       <= '0;
      slot_q         <= '0;
      seg_cnt_q      <= '0;
      pend_addr_q    <= '0;
      pend_len_q     <= '0;
      err_too_big_o  <= 1'b0;
      err_overflow_o <= 1'b0;
      done_o         <= 1'b0;
      bnc_valid_o    <= 1'b0;
      bnc_slot_o     <= '0;
      bnc_bytes_o    <= '0;
      bnc_to_card_o  <= 1'b0;
    end else begin
      done_o      <= 1'b0;
      bnc_valid_o <= 1'b0;
      if (start_i) begin
        state_q        <= ST_TAKE;
        wr_ptr_q       <= '0;
        slot_q         <= '0;
        seg_cnt_q      <= '0;
        err_too_big_o  <= 1'b0;
        err_overflow_o <= 1'b0;
      end else begin
        if (wr_en) wr_ptr_q <= wr_ptr_q + IDX_W'(1);
        unique case (state_q)
          ST_TAKE: begin
            if (ovf_evt) err_overflow_o <= 1'b1;
            if (big_evt) err_too_big_o  <= 1'b1;
            if (good_take) seg_cnt_q <= seg_cnt_q + SEGC_W'(1);
            if (head_evt) begin
              slot_q        <= slot_q + SLOT_W'(1);
              bnc_valid_o   <= 1'b1;
              bnc_slot_o    <= slot_q;
              bnc_bytes_o   <= sp_head;
              bnc_to_card_o <= seg_to_card_i;
              pend_addr_q   <= sp_body_addr;
              pend_len_q    <= sp_body_len;
              state_q       <= ST_BODY;
            end else if (fin_evt) begin
              done_o  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          ST_BODY: state_q <= ST_TAKE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign desc_count_o = wr_ptr_q;

  // ---------------- assertions ----------------
  assert_ptr_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_ptr_q < IDX_W'(DEPTH)));

  assert_slot_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (head_evt && !start_i) |=> (slot_q == $past(slot_q) + SLOT_W'(1)));

  assert_notice_pause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bnc_valid_o && !$past(start_i)) |-> !seg_ready_o);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |-> !seg_ready_o);

  assert_big_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_too_big_o && !start_i) |=> err_too_big_o);

  assert_halt_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_too_big_o || err_overflow_o) |-> !(head_evt || direct_evt || end_evt));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overflow_o && !start_i) |=> err_overflow_o);

  assert_seg_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seg_cnt_q <= SEGC_W'(MAX_SEG));

  assert_empty_seg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (good_take && seg_len_i == '0) |-> !wr_en);

endmodule

// File: tb/tb_sg_table_builder.sv
`timescale 1ns/1ps
module tb_sg_table_builder;

  localparam logic [31:0] BB = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, seg_valid_i = 1'b0, seg_to_card_i = 1'b0, finish_i = 1'b0;
  logic [31:0] seg_addr_i = '0;
  logic [16:0] seg_len_i = '0;
  logic [8:0]  rd_idx_i = '0;
  logic        seg_ready_o, done_o, err_too_big_o, err_overflow_o;
  logic        bnc_valid_o, bnc_to_card_o;
  logic [8:0]  desc_count_o;
  logic [6:0]  bnc_slot_o;
  logic [1:0]  bnc_bytes_o;
  logic [63:0] rd_data_o;

  always #2.5 clk = ~clk;

  sg_table_builder #(.BOUNCE_BASE(BB)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .seg_valid_i(seg_valid_i),
    .seg_ready_o(seg_ready_o), .seg_addr_i(seg_addr_i), .seg_len_i(seg_len_i),
    .seg_to_card_i(seg_to_card_i), .finish_i(finish_i), .done_o(done_o),
    .desc_count_o(desc_count_o), .err_too_big_o(err_too_big_o),
    .err_overflow_o(err_overflow_o), .bnc_valid_o(bnc_valid_o),
    .bnc_slot_o(bnc_slot_o), .bnc_bytes_o(bnc_bytes_o),
    .bnc_to_card_o(bnc_to_card_o), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
  );

  int n_chk = 0, n_bad = 0;
  bit ended = 0, mon_on = 0;

  // Reference model state
  logic [63:0] exp_tab[$];
  string       exp_tag[$];
  int          exp_slot[$], exp_bytes[$];
  bit          exp_dir[$];
  int          m_seg = 0, m_slot = 0;
  bit          m_big = 0, m_ovf = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] entry(input int attr, input int len, input logic [31:0] addr);
    logic [63:0] e;
    e = {addr, 16'(len % 65536), 8'h00, 8'(attr)};
    return e;
  endfunction

  task automatic model_seg(input logic [31:0] a, input int len, input bit dir);
    int head, body;
    if (m_big || m_ovf) return;
    if (m_seg == 128) begin m_ovf = 1; return; end
    if (len > 65536) begin m_big = 1; return; end
    m_seg++;
    head = (4 - int'(a[1:0])) % 4;
    if (head > len) head = len;
    if (head > 0) begin
      exp_tab.push_back(entry(33, head, BB + 32'(4 * m_slot)));
      exp_tag.push_back("R3 head");
      exp_slot.push_back(m_slot); exp_bytes.push_back(head); exp_dir.push_back(dir);
      m_slot++;
    end
    body = len - head;
    if (body > 0) begin
      exp_tab.push_back(entry(33, body, a + 32'(head)));
      exp_tag.push_back(head > 0 ? "R3 body" : "R2 aligned");
    end
  endtask

  task automatic send_seg(input logic [31:0] a, input int len, input bit dir);
    @(negedge clk);
    seg_addr_i = a; seg_len_i = 17'(len); seg_to_card_i = dir; seg_valid_i = 1'b1;
    while (!seg_ready_o) @(negedge clk);
    @(posedge clk);
    model_seg(a, len, dir);
    @(negedge clk);
    seg_valid_i = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    exp_tab.delete(); exp_tag.delete();
    m_seg = 0; m_slot = 0; m_big = 0; m_ovf = 0;
    @(negedge clk);
    start_i = 1'b0;
    check(seg_ready_o == 1'b1, "R9 ready after start", 64'(seg_ready_o), 64'd1);
    check(desc_count_o == 9'd0, "R9 count cleared", 64'(desc_count_o), 64'd0);
  endtask

  task automatic do_finish();
    @(negedge clk);
    finish_i = 1'b1;
    @(posedge clk);
    if (!(m_big || m_ovf)) begin
      exp_tab.push_back(entry(3, 0, 32'h0));
      exp_tag.push_back("R5 end entry");
    end
    @(negedge clk);
    finish_i = 1'b0;
    check(done_o == 1'b1, "R5 done pulse", 64'(done_o), 64'd1);
    check(desc_count_o == 9'(exp_tab.size()), (m_big || m_ovf) ? "R6 R7 count" : "R5 count",
          64'(desc_count_o), 64'(exp_tab.size()));
    @(negedge clk);
    check(done_o == 1'b0, "R5 done one cycle", 64'(done_o), 64'd0);
    check(seg_ready_o == 1'b0, "R5 closed", 64'(seg_ready_o), 64'd0);
    // R1 table read-back
    for (int i = 0; i < exp_tab.size(); i++) begin
      rd_idx_i = 9'(i);
      #0.5;
      check(rd_data_o == exp_tab[i], $sformatf("R1 %s idx %0d", exp_tag[i], i), rd_data_o, exp_tab[i]);
    end
  endtask

  // Every-clock comparison of flags and bounce notices against the model
  always @(negedge clk) begin
    if (mon_on) begin
      check(err_too_big_o == m_big, "R6 flag", 64'(err_too_big_o), 64'(m_big));
      check(err_overflow_o == m_ovf, "R7 flag", 64'(err_overflow_o), 64'(m_ovf));
      if (bnc_valid_o) begin
        if (exp_slot.size() == 0) begin
          check(1'b0, "R4 unexpected notice", 64'(bnc_slot_o), 64'd0);
        end else begin
          check(bnc_slot_o == 7'(exp_slot[0]), "R4 slot", 64'(bnc_slot_o), 64'(exp_slot[0]));
          check(bnc_bytes_o == 2'(exp_bytes[0]), "R4 bytes", 64'(bnc_bytes_o), 64'(exp_bytes[0]));
          check(bnc_to_card_o == exp_dir[0], "R4 dir", 64'(bnc_to_card_o), 64'(exp_dir[0]));
          void'(exp_slot.pop_front()); void'(exp_bytes.pop_front()); void'(exp_dir.pop_front());
        end
      end
    end
  end

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(seg_ready_o == 1'b0, "R9 ready low", 64'(seg_ready_o), 64'd0);
    check(done_o == 1'b0, "R9 done low", 64'(done_o), 64'd0);
    check(err_too_big_o == 1'b0, "R9 big low", 64'(err_too_big_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(seg_ready_o == 1'b0, "R9 no start yet", 64'(seg_ready_o), 64'd0);
    mon_on = 1;

    // Mixed table: aligned, max length, unaligned splits, head-only, empty (R8)
    do_start();
    send_seg(32'h0000_2000, 512, 0);      // R2
    send_seg(32'h0000_3000, 65536, 1);    // R2 length 65536 stored as 0
    send_seg(32'h0000_4001, 100, 0);      // R3 head 3, body 97
    send_seg(32'h0000_5002, 2, 1);        // R3 head only
    send_seg(32'h0000_6003, 1, 0);        // R3 head 1
    send_seg(32'h0000_7001, 1, 1);        // R3 clipped head
    send_seg(32'h0000_8000, 0, 0);        // R8 nothing written
    send_seg(32'h0000_9002, 66, 1);       // R3 head 2, body 64
    send_seg(32'h0000_A003, 65536, 0);    // R3 head 1, body 65535
    do_finish();

    // Too-big segment halts building (R6); slot restarts at 0 (R4)
    do_start();
    send_seg(32'h0001_0001, 10, 1);
    send_seg(32'h0001_1000, 65537, 0);
    send_seg(32'h0001_2000, 8, 0);
    send_seg(32'h0001_3001, 8, 0);
    do_finish();

    // Full table then overflow (R7, R10)
    do_start();
    for (int i = 0; i < 128; i++) send_seg(32'h0010_0001 + 32'(i * 16), 8, i[0]);
    send_seg(32'h0020_0000, 16, 0);
    send_seg(32'h0020_0001, 16, 0);
    do_finish();

    // Recovery after error (R9)
    do_start();
    check(err_overflow_o == 1'b0, "R9 errors cleared", 64'(err_overflow_o), 64'd0);
    send_seg(32'h0030_0000, 4, 0);
    do_finish();

    repeat (2) @(negedge clk);
    check(exp_slot.size() == 0, "R4 all notices seen", 64'(exp_slot.size()), 64'd0);
    report();
  end

endmodule